// File: doc/BRIEF.md
# Storage-Alteration Event Detector

This block sits beside a processor core's store path and watches every store it issues. When event monitoring is switched on and a store writes at least one byte inside a programmable address window, the block reports a storage-alteration event. It reports it in the same cycle the store is presented, so the core can hold back the write and run the instruction again once the event has been taken.

The window is given by an inclusive lower bound and an inclusive upper bound. When the lower bound is above the upper bound, the window wraps past the top of the address space. A lower bound of zero with an all-ones upper bound covers every address.

On a hit the block does three things. It keeps the address of the storing instruction. It ORs an event code into a sticky code register; that code is a store-event flag plus the current address-space-control value. It then raises a one-cycle pending pulse. The exception logic clears the code register when it takes the event.

Top module: `sa_event_detect`

## Requirements
- R1: `st_block` is high only while `st_valid`, `psw_mon_en` and bit SA_BIT (default 5) of `evt_mask` are all high; if any of them is low, no event is recorded.
- R2: With `win_lo` <= `win_hi`, a byte at address X is watched exactly when `win_lo` <= X <= `win_hi`; both bounds are included.
- R3: With `win_lo` > `win_hi`, the watched addresses are `win_lo` through the all-ones address, together with zero through `win_hi`.
- R4: With `win_lo` = 0 and `win_hi` = all ones, a store at any address hits.
- R5: A store covers `st_len_m1`+1 bytes, from `st_addr` upward. The byte addresses wrap modulo 2^AW. The store hits if any of its bytes is watched.
- R6: `st_block` is combinational and rises in the same cycle as the store it flags.
- R7: `evt_pend` is high for exactly the one cycle after each cycle in which `st_block` is high, and low at all other times.
- R8: In the cycle after a hit, `evt_addr` holds the `inst_addr` value of the hit cycle. At all other times it keeps its value.
- R9: A hit ORs a code into `evt_code`. The code sets bit 7 (the store-event flag) and places `psw_asc` in bits 1:0. All other bits stay zero. Earlier bits are kept, so the register is sticky.
- R10: `evt_clr` clears `evt_code` at the next edge. If a hit occurs in the same cycle, the register holds only that hit's code.
- R11: While `rst_n` is low, `evt_pend`, `evt_addr` and `evt_code` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_valid | input | 1 | A store is presented this cycle |
| st_addr | input | AW | Lowest byte address of the store |
| st_len_m1 | input | LW | Store length in bytes minus one |
| inst_addr | input | AW | Address of the instruction issuing the store |
| psw_mon_en | input | 1 | Master event-monitoring enable from the status word |
| psw_asc | input | 2 | Address-space-control value from the status word |
| evt_mask | input | MW | Event-mask control register; bit SA_BIT enables this event |
| win_lo | input | AW | Inclusive start of the watched window |
| win_hi | input | AW | Inclusive end of the watched window |
| evt_clr | input | 1 | Clears the event code register when the event is taken |
| st_block | output | 1 | Hit in this cycle; hold back the store |
| evt_pend | output | 1 | One-cycle pulse that reports a recorded event |
| evt_addr | output | AW | Captured address of the storing instruction |
| evt_code | output | CW | Sticky event code: bit 7 store flag, bits 1:0 address-space control |

## Verification
The assertions check every cycle for the properties that hold no matter what the window holds:
- the enable gating of `st_block`;
- the pulse that follows each hit;
- the capture of the instruction address;
- the sticky and clear behaviour of the code register.

Only the bench's scenarios can show that the range comparison is right. These scenarios cover:
- both bounds of a plain window;
- a wrapped window and its gap;
- the whole-space setting;
- multi-byte stores that reach into the window or wrap past the top address.

// File: rtl/sa_event_detect.sv
module sa_event_detect #(
  parameter int AW     = 64,
  parameter int LW     = 4,
  parameter int MW     = 8,
  parameter int SA_BIT = 5,
  parameter int CW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [LW-1:0] st_len_m1,
  input  logic [AW-1:0] inst_addr,
  input  logic          psw_mon_en,
  input  logic [1:0]    psw_asc,
  input  logic [MW-1:0] evt_mask,
  input  logic [AW-1:0] win_lo,
  input  logic [AW-1:0] win_hi,
  input  logic          evt_clr,
  output logic          st_block,
  output logic          evt_pend,
  output logic [AW-1:0] evt_addr,
  output logic [CW-1:0] evt_code
);

  function automatic logic on_arc(input logic [AW-1:0] x, lo, hi);
    if (lo <= hi) return (x >= lo) && (x <= hi);
    else          return (x >= lo) || (x <= hi);
  endfunction

  logic [AW-1:0] st_last;
  logic          armed, overlap;
  logic [CW-1:0] hit_code;

  assign st_last  = st_addr + {{(AW-LW){1'b0}}, st_len_m1};
  assign armed    = st_valid && psw_mon_en && evt_mask[SA_BIT];
  assign overlap  = on_arc(st_addr, win_lo, win_hi) || on_arc(win_lo, st_addr, st_last);
  assign st_block = armed && overlap;
  assign hit_code = {1'b1, {(CW-3){1'b0}}, psw_asc};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_pend <= 1'b0;
      evt_addr <= '0;
      evt_code <= '0;
    end else begin
      evt_pend <= st_block;
      if (st_block) evt_addr <= inst_addr;
      evt_code <= (evt_clr ? '0 : evt_code) | (st_block ? hit_code : '0);
    end
  end

endmodule

module sa_event_detect_chk #(
  parameter int AW     = 64,
  parameter int MW     = 8,
  parameter int SA_BIT = 5,
  parameter int CW     = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          st_valid,
  input logic          psw_mon_en,
  input logic [1:0]    psw_asc,
  input logic [MW-1:0] evt_mask,
  input logic [AW-1:0] inst_addr,
  input logic          evt_clr,
  input logic          st_block,
  input logic          evt_pend,
  input logic [AW-1:0] evt_addr,
  input logic [CW-1:0] evt_code
);

  AST_BLOCK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    st_block |-> (st_valid && psw_mon_en && evt_mask[SA_BIT])); // R1

  AST_PEND_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    st_block |=> evt_pend); // R7

  AST_PEND_ONLY_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !st_block |=> !evt_pend); // R7

  AST_ADDR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    st_block |=> evt_addr == $past(inst_addr)); // R8

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !st_block |=> $stable(evt_addr)); // R8

  AST_CODE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    st_block |=> evt_code[CW-1] && ((evt_code[1:0] & $past(psw_asc)) == $past(psw_asc))); // R9

  AST_CODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_block && !evt_clr) |=> $stable(evt_code)); // R9

  AST_CODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_clr && !st_block) |=> evt_code == '0); // R10

endmodule

bind sa_event_detect sa_event_detect_chk #(.AW(AW), .MW(MW), .SA_BIT(SA_BIT), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .psw_mon_en(psw_mon_en),
  .psw_asc(psw_asc), .evt_mask(evt_mask), .inst_addr(inst_addr), .evt_clr(evt_clr),
  .st_block(st_block), .evt_pend(evt_pend), .evt_addr(evt_addr), .evt_code(evt_code)
);

// File: tb/sa_event_detect_bench.sv
`timescale 1ns/100ps
module sa_event_detect_bench;
  localparam logic [63:0] M = 64'hFFFF_FFFF_FFFF_FFFF;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        st_valid = 1'b0, psw_mon_en = 1'b0, evt_clr = 1'b0;
  logic [63:0] st_addr = '0, inst_addr = '0, win_lo = '0, win_hi = '0;
  logic [3:0]  st_len_m1 = '0;
  logic [1:0]  psw_asc = '0;
  logic [7:0]  evt_mask = '0;
  logic        st_block, evt_pend;
  logic [63:0] evt_addr;
  logic [7:0]  evt_code;

  int total = 0, bad = 0;
  logic [7:0] exp_code = '0;
  bit done = 0;

  sa_event_detect u_sa_event_detect (.*);

  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [63:0] lo, hi, a;
    logic [3:0]  lm1;
    logic        mon, en, hit;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{64'd100, 64'd200, 64'd100, 4'd0, 1'b1, 1'b1, 1'b1},   // R2 lower bound
    '{64'd100, 64'd200, 64'd200, 4'd0, 1'b1, 1'b1, 1'b1},   // R2 upper bound
    '{64'd100, 64'd200, 64'd201, 4'd0, 1'b1, 1'b1, 1'b0},   // R2 above
    '{64'd100, 64'd200, 64'd99,  4'd0, 1'b1, 1'b1, 1'b0},   // R2 below
    '{64'd100, 64'd200, 64'd98,  4'd1, 1'b1, 1'b1, 1'b0},   // R5 ends just short
    '{64'd100, 64'd200, 64'd98,  4'd2, 1'b1, 1'b1, 1'b1},   // R5 last byte inside
    '{64'd100, 64'd200, 64'd150, 4'd0, 1'b0, 1'b1, 1'b0},   // R1 monitoring off
    '{64'd100, 64'd200, 64'd150, 4'd0, 1'b1, 1'b0, 1'b0},   // R1 event bit off
    '{M-15,    64'd16,  M,       4'd0, 1'b1, 1'b1, 1'b1},   // R3 top
    '{M-15,    64'd16,  64'd0,   4'd0, 1'b1, 1'b1, 1'b1},   // R3 zero
    '{M-15,    64'd16,  64'd16,  4'd0, 1'b1, 1'b1, 1'b1},   // R3 end bound
    '{M-15,    64'd16,  64'd17,  4'd0, 1'b1, 1'b1, 1'b0},   // R3 gap low
    '{M-15,    64'd16,  M-16,    4'd0, 1'b1, 1'b1, 1'b0},   // R3 gap high
    '{M-15,    64'd16,  64'd20,  4'd14,1'b1, 1'b1, 1'b0},   // R3 store inside gap
    '{M-15,    64'd16,  M-17,    4'd2, 1'b1, 1'b1, 1'b1},   // R3 store reaching start
    '{64'd0,   M,       64'd12345,4'd0,1'b1, 1'b1, 1'b1},   // R4
    '{64'd0,   M,       M,       4'd15,1'b1, 1'b1, 1'b1},   // R4 wrapping store
    '{64'd2,   64'd5,   M-1,     4'd3, 1'b1, 1'b1, 1'b0},   // R5 store wraps, misses
    '{64'd2,   64'd5,   M-1,     4'd4, 1'b1, 1'b1, 1'b1},   // R5 store wraps, hits
    '{M-3,     M,       M-5,     4'd2, 1'b1, 1'b1, 1'b1},   // R5 window at top
    '{M-3,     M,       M-5,     4'd1, 1'b1, 1'b1, 1'b0},   // R5 window at top, short
    '{64'd10,  64'd10,  64'd10,  4'd0, 1'b1, 1'b1, 1'b1}    // R2 single-byte window
  };

  task automatic check(input string req, input logic [63:0] act, exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // drive at negedge, check comb, step one edge, check registers
  task automatic step(input logic [63:0] a, input logic [3:0] lm1, input logic v,
                      input logic [1:0] asc, input logic clr, input logic [63:0] ia,
                      input logic exp_hit, input string req);
    logic [63:0] prev_addr;
    prev_addr = evt_addr;
    st_addr = a; st_len_m1 = lm1; st_valid = v; psw_asc = asc; evt_clr = clr; inst_addr = ia;
    #1;
    check({req, " R6 st_block"}, {63'd0, st_block}, {63'd0, exp_hit});
    exp_code = (clr ? 8'h00 : exp_code) | (exp_hit ? {6'b100000, asc} : 8'h00);
    @(negedge clk);
    check({req, " R7 evt_pend"}, {63'd0, evt_pend}, {63'd0, exp_hit});
    check({req, " R8 evt_addr"}, evt_addr, exp_hit ? ia : prev_addr);
    check({req, " R9/R10 evt_code"}, {56'd0, evt_code}, {56'd0, exp_code});
    st_valid = 1'b0; evt_clr = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R11 pend at reset", {63'd0, evt_pend}, 64'd0);
    check("R11 addr at reset", evt_addr, 64'd0);
    check("R11 code at reset", {56'd0, evt_code}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      win_lo = VECS[i].lo; win_hi = VECS[i].hi;
      psw_mon_en = VECS[i].mon;
      evt_mask = VECS[i].en ? 8'h20 : 8'hDF;
      step(VECS[i].a, VECS[i].lm1, 1'b1, 2'(i % 4), (i % 3) == 0,
           64'h4000 + 64'(i) * 4, VECS[i].hit, $sformatf("vec%0d", i));
    end

    // R1: no valid strobe, everything else matching
    win_lo = 64'd0; win_hi = M; psw_mon_en = 1'b1; evt_mask = 8'h20;
    step(64'd500, 4'd0, 1'b0, 2'd1, 1'b0, 64'h9000, 1'b0, "R1 no strobe");

    // R10 + R9: clear first, then sticky accumulation of two ASC values
    step(64'd500, 4'd0, 1'b0, 2'd0, 1'b1, 64'h9000, 1'b0, "R10 clear only");
    step(64'd600, 4'd0, 1'b1, 2'd1, 1'b0, 64'h9100, 1'b1, "R9 first hit");
    step(64'd700, 4'd0, 1'b1, 2'd2, 1'b0, 64'h9200, 1'b1, "R9 second hit");
    check("R9 sticky asc OR", {56'd0, evt_code}, 64'h83);
    // R7: pulse lasts one cycle
    step(64'd700, 4'd0, 1'b0, 2'd2, 1'b0, 64'h9300, 1'b0, "R7 pulse ends");
    // R10: clear with simultaneous hit keeps only the new code
    step(64'd800, 4'd0, 1'b1, 2'd0, 1'b1, 64'h9400, 1'b1, "R10 clear+hit");
    check("R10 only new code", {56'd0, evt_code}, 64'h80);

    // R11: reset in the middle of a run
    step(64'd900, 4'd0, 1'b1, 2'd3, 1'b0, 64'h9500, 1'b1, "pre-reset hit");
    rst_n = 1'b0; #1;
    check("R11 pend mid reset", {63'd0, evt_pend}, 64'd0);
    check("R11 addr mid reset", evt_addr, 64'd0);
    check("R11 code mid reset", {56'd0, evt_code}, 64'd0);
    @(negedge clk);
    finish_run();
  end
endmodule